// File: doc/BRIEF.md
# Digital Compare Band Detector

This block sorts each new converter sample into one of three bands set by two programmable thresholds: low, mid and high. It then decides for two separate outputs, an interrupt request and a conversion trigger, whether the sample should raise a one-cycle pulse. Each output has its own band select and its own mode. A mode either responds to every in-band sample or to band entry only, and it may or may not apply hysteresis.

The hysteresis modes keep one bit of history per output between samples. A high-band select stays active through mid-band samples until a sample reaches the low band, and a low-band select mirrors this. Each output also has a write strobe that marks a write to its mode or band field. The strobe clears that output's history. Software keeps the lower threshold no greater than the upper threshold.

Top module: `band_watch`

## Requirements
- R1: A sample is high band when it is greater than or equal to `thr_hi`, low band when it is below `thr_lo`, and mid band otherwise. Band select codes are 0 = low, 1 = mid, 3 = high.
- R2: Mode 0 (Always) pulses on every sample that falls in the selected band.
- R3: Mode 1 (Once) pulses on the first in-band sample after reset or after a field write. It then pulses again only after a sample has fallen outside the band.
- R4: Mode 2 (Hysteresis Always) with a high (low) band select pulses on every sample from an in-band sample onward, including mid-band samples. It stops at the first low-band (high-band) sample.
- R5: Mode 3 (Hysteresis Once) with a high (low) band select pulses once on entering the band. It is re-armed only by a low-band (high-band) sample.
- R6: Band select code 2 never pulses, in any mode. A mid-band select never pulses in modes 2 or 3.
- R7: A pulse appears for exactly one cycle, in the cycle after `smp_vld` is high. With no strobe there is no pulse.
- R8: A field write strobe clears that output's history. A sample that arrives in the same cycle as the strobe produces no pulse on that output.
- R9: The interrupt path and the trigger path keep separate history. A write strobe or a band state on one path never changes the pulses of the other.
- R10: After a synchronous reset both outputs are low and both histories are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | New sample strobe |
| smp | input | 12 | Sample value |
| thr_lo | input | 12 | Lower threshold |
| thr_hi | input | 12 | Upper threshold |
| irq_mode | input | 2 | Interrupt mode code |
| irq_band | input | 2 | Interrupt band select |
| irq_cfg_wr | input | 1 | Interrupt field write strobe |
| trg_mode | input | 2 | Trigger mode code |
| trg_band | input | 2 | Trigger band select |
| trg_cfg_wr | input | 1 | Trigger field write strobe |
| irq_pulse | output | 1 | Interrupt pulse |
| trg_pulse | output | 1 | Trigger pulse |

## Verification
The hardest state to reach from the ports is the held hysteresis bit. A pulse on a mid-band sample shows it only if an earlier sample entered the band and no opposite-band sample has come since. The stimulus therefore walks ordered sequences of mid, high and low samples for each mode and checks every step. A second hard case is a write strobe that lands in the same cycle as a sample. The bench drives both in one cycle and checks that only the written path drops its pulse, while the other path's history is still intact.

// File: rtl/band_watch_pkg.sv
package band_watch_pkg;
  localparam logic [1:0] BAND_LO  = 2'd0;
  localparam logic [1:0] BAND_MID = 2'd1;
  localparam logic [1:0] BAND_RSV = 2'd2;
  localparam logic [1:0] BAND_HI  = 2'd3;

  localparam logic [1:0] MODE_ALL   = 2'd0;
  localparam logic [1:0] MODE_ONE   = 2'd1;
  localparam logic [1:0] MODE_H_ALL = 2'd2;
  localparam logic [1:0] MODE_H_ONE = 2'd3;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] band;
    logic       wr;
  } path_cfg_t;
endpackage

// File: rtl/band_classify.sv
module band_classify #(
  parameter int SMP_W = 12
) (
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] thr_lo,
  input  logic [SMP_W-1:0] thr_hi,
  output logic [1:0]       band
);
  import band_watch_pkg::*;

  always_comb begin
    if (smp >= thr_hi)     band = BAND_HI;
    else if (smp < thr_lo) band = BAND_LO;
    else                   band = BAND_MID;
  end
endmodule

// File: rtl/band_path.sv
module band_path (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_vld,
  input  logic [1:0]                 cls,
  input  band_watch_pkg::path_cfg_t  cfg,
  output logic                       pulse
);
  import band_watch_pkg::*;

  logic hist_q, hist_d, fire;
  logic in_band, opp_band, hyst_ok, hyst_next;

  always_comb begin
    in_band  = (cfg.band != BAND_RSV) && (cls == cfg.band);
    opp_band = ((cfg.band == BAND_HI) && (cls == BAND_LO)) ||
               ((cfg.band == BAND_LO) && (cls == BAND_HI));
    hyst_ok  = (cfg.band == BAND_HI) || (cfg.band == BAND_LO);
    hyst_next = in_band ? 1'b1 : (opp_band ? 1'b0 : hist_q);
    hist_d = hist_q;
    fire   = 1'b0;
    case (cfg.mode)
      MODE_ALL: fire = in_band;
      MODE_ONE: begin
        fire   = in_band && !hist_q;
        hist_d = in_band;
      end
      MODE_H_ALL: begin
        hist_d = hyst_next;
        fire   = hyst_next && hyst_ok;
      end
      default: begin
        hist_d = hyst_next;
        fire   = in_band && !hist_q && hyst_ok;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || cfg.wr) begin
      hist_q <= 1'b0;
      pulse  <= 1'b0;
    end else if (smp_vld) begin
      hist_q <= hist_d;
      pulse  <= fire;
    end else begin
      pulse  <= 1'b0;
    end
  end
endmodule

// File: rtl/band_watch.sv
module band_watch #(
  parameter int SMP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] thr_lo,
  input  logic [SMP_W-1:0] thr_hi,
  input  logic [1:0]       irq_mode,
  input  logic [1:0]       irq_band,
  input  logic             irq_cfg_wr,
  input  logic [1:0]       trg_mode,
  input  logic [1:0]       trg_band,
  input  logic             trg_cfg_wr,
  output logic             irq_pulse,
  output logic             trg_pulse
);
  import band_watch_pkg::*;

  localparam int NPATH = 2;

  logic [1:0]   cls;
  path_cfg_t    cfg   [NPATH];
  logic [NPATH-1:0] pulses;

  band_classify #(.SMP_W(SMP_W)) u_cls (
    .smp(smp), .thr_lo(thr_lo), .thr_hi(thr_hi), .band(cls)
  );

  assign cfg[0] = '{mode: irq_mode, band: irq_band, wr: irq_cfg_wr};
  assign cfg[1] = '{mode: trg_mode, band: trg_band, wr: trg_cfg_wr};

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    band_path u_path (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .cls(cls),
      .cfg(cfg[g]), .pulse(pulses[g])
    );
  end

  assign irq_pulse = pulses[0];
  assign trg_pulse = pulses[1];
endmodule

// File: rtl/band_watch_chk.sv
module band_watch_chk #(
  parameter int SMP_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_vld,
  input logic [SMP_W-1:0] smp,
  input logic [SMP_W-1:0] thr_lo,
  input logic [SMP_W-1:0] thr_hi,
  input logic [1:0]       irq_mode,
  input logic [1:0]       irq_band,
  input logic             irq_cfg_wr,
  input logic [1:0]       trg_mode,
  input logic [1:0]       trg_band,
  input logic             trg_cfg_wr,
  input logic             irq_pulse,
  input logic             trg_pulse
);
  a_r7_irq_needs_sample: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(smp_vld));
  a_r7_trg_needs_sample: assert property (@(posedge clk) disable iff (rst)
    trg_pulse |-> $past(smp_vld));
  a_r2_irq_always_high: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !irq_cfg_wr && irq_mode == 2'd0 && irq_band == 2'd3 && smp >= thr_hi)
    |=> irq_pulse);
  a_r1_trg_always_low: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !trg_cfg_wr && trg_mode == 2'd0 && trg_band == 2'd0 && smp < thr_lo)
    |=> trg_pulse);
  a_r6_irq_reserved: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(irq_band) != 2'd2);
  a_r6_trg_reserved: assert property (@(posedge clk) disable iff (rst)
    trg_pulse |-> $past(trg_band) != 2'd2);
  a_r8_irq_write_quiet: assert property (@(posedge clk) disable iff (rst)
    irq_cfg_wr |=> !irq_pulse);
  a_r8_trg_write_quiet: assert property (@(posedge clk) disable iff (rst)
    trg_cfg_wr |=> !trg_pulse);
endmodule

bind band_watch band_watch_chk #(.SMP_W(SMP_W)) u_chk (.*);

// File: tb/sim_band_watch.sv
`timescale 1ns/1ps
module sim_band_watch;
  localparam int W = 12;
  localparam logic [W-1:0] LO = 12'd1000, HI = 12'd3000;
  localparam logic [W-1:0] SL = 12'd500, SM = 12'd2000, SH = 12'd3500;

  logic clk = 1'b0, rst = 1'b1, smp_vld = 1'b0;
  logic [W-1:0] smp = '0;
  logic [W-1:0] thr_lo = LO, thr_hi = HI;
  logic [1:0] irq_mode = 2'd0, irq_band = 2'd0, trg_mode = 2'd0, trg_band = 2'd0;
  logic irq_cfg_wr = 1'b0, trg_cfg_wr = 1'b0;
  logic irq_pulse, trg_pulse;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  band_watch #(.SMP_W(W)) u0 (.*);

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] im, input logic [1:0] ib, input logic iw,
                     input logic [1:0] tm, input logic [1:0] tb, input logic tw);
    @(negedge clk);
    if (iw) begin irq_mode = im; irq_band = ib; irq_cfg_wr = 1'b1; end
    if (tw) begin trg_mode = tm; trg_band = tb; trg_cfg_wr = 1'b1; end
    @(negedge clk);
    irq_cfg_wr = 1'b0; trg_cfg_wr = 1'b0;
  endtask

  task automatic send(input logic [W-1:0] s, input logic ei, input logic et,
                      input string tag, input logic iw = 1'b0, input logic tw = 1'b0);
    @(negedge clk);
    smp = s; smp_vld = 1'b1; irq_cfg_wr = iw; trg_cfg_wr = tw;
    @(negedge clk);
    smp_vld = 1'b0; irq_cfg_wr = 1'b0; trg_cfg_wr = 1'b0;
    check(irq_pulse, ei, {tag, " irq"});
    check(trg_pulse, et, {tag, " trg"});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(irq_pulse, 1'b0, "R10 reset irq");
    check(trg_pulse, 1'b0, "R10 reset trg");
    rst = 1'b0;
  endtask

  task automatic t_always();
    cfg(2'd0, 2'd3, 1'b1, 2'd0, 2'd0, 1'b1);
    send(SH, 1, 0, "R2 high");
    @(negedge clk);
    check(irq_pulse, 1'b0, "R7 one cycle irq");
    send(SM, 0, 0, "R2 mid");
    send(SL, 0, 1, "R2 low");
    send(12'd3000, 1, 0, "R1 at hi");
    send(12'd2999, 0, 0, "R1 below hi");
    send(12'd999, 0, 1, "R1 below lo");
    send(12'd1000, 0, 0, "R1 at lo");
    repeat (2) @(negedge clk);
    check(irq_pulse, 1'b0, "R7 idle irq");
    check(trg_pulse, 1'b0, "R7 idle trg");
  endtask

  task automatic t_once();
    cfg(2'd1, 2'd3, 1'b1, 2'd1, 2'd1, 1'b1);
    send(SH, 1, 0, "R3 s1");
    send(SH, 0, 0, "R3 s2");
    send(SM, 0, 1, "R3 s3");
    send(SM, 0, 0, "R3 s4");
    send(SH, 1, 0, "R3 s5");
    send(SL, 0, 0, "R3 s6");
    send(SM, 0, 1, "R3 s7");
  endtask

  task automatic t_hyst_all();
    cfg(2'd2, 2'd3, 1'b1, 2'd2, 2'd0, 1'b1);
    send(SM, 0, 0, "R4 s1");
    send(SH, 1, 0, "R4 s2");
    send(SM, 1, 0, "R4 s3");
    send(SL, 0, 1, "R4 s4");
    send(SM, 0, 1, "R4 s5");
    send(SH, 1, 0, "R4 s6");
    send(SM, 1, 0, "R4 s7");
  endtask

  task automatic t_hyst_once();
    cfg(2'd3, 2'd3, 1'b1, 2'd3, 2'd0, 1'b1);
    send(SH, 1, 0, "R5 s1");
    send(SM, 0, 0, "R5 s2");
    send(SH, 0, 0, "R5 s3");
    send(SL, 0, 1, "R5 s4");
    send(SM, 0, 0, "R5 s5");
    send(SH, 1, 0, "R5 s6");
    send(SL, 0, 1, "R5 s7");
    send(SL, 0, 0, "R5 s8");
  endtask

  task automatic t_never();
    cfg(2'd2, 2'd1, 1'b1, 2'd0, 2'd2, 1'b1);
    send(SL, 0, 0, "R6 low");
    send(SM, 0, 0, "R6 mid");
    send(SH, 0, 0, "R6 high");
    cfg(2'd3, 2'd1, 1'b1, 2'd1, 2'd2, 1'b1);
    send(SM, 0, 0, "R6 mid once");
  endtask

  task automatic t_write();
    cfg(2'd3, 2'd3, 1'b1, 2'd1, 2'd3, 1'b1);
    send(SH, 1, 1, "R8 first");
    send(SH, 0, 0, "R8 held");
    cfg(2'd3, 2'd3, 1'b1, 2'd0, 2'd0, 1'b0);
    send(SH, 1, 0, "R9 irq rearmed trg kept");
    irq_mode = 2'd0;
    send(SH, 0, 0, "R8 same cycle", 1'b1, 1'b0);
    send(SH, 1, 0, "R8 after write");
    trg_mode = 2'd0;
    send(SH, 1, 0, "R9 trg write irq intact", 1'b0, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_always();
        t_once();
        t_hyst_all();
        t_hyst_once();
        t_never();
        t_write();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule